// File: doc/BRIEF.md
# Latched Interrupt Request Generator

This block raises a single active-low interrupt request toward a processor whose interrupt controller treats a request that vanishes before acknowledge as a fault. Events from a subsystem arrive as asynchronous level changes on one or more source lines. Each line is synchronized and edge-detected, and a rising edge sets a request latch while the enable bit is on. The request pin is the output of that latch's flip-flop.

Once the pin is low it stays low until the service routine writes the clear strobe. Turning the enable off only blocks new requests and never releases a pending one. A set and a clear in the same cycle resolve in favour of the set, so no event is lost.

A counter records every new assertion of the request. It sits on its own power-on reset, so its value survives a processor reset. Software reaches the enable, the clear and the counter through a small strobe/address port.

Top module: `irq_hold_gen`

## Requirements
- R1: `irq_n` is active low. While `cpu_rst_n` is low, and for the two clock edges after it rises, `irq_n` is 1 and the enable bit is 0.
- R2: Once `irq_n` is 0, it stays 0 until a cycle with `wr_stb`=1, `wr_addr`=1 and `wr_bit`=1. At that edge it returns to 1. No other write and no event deasserts it.
- R3: A write to address 0 loads `wr_bit` into the enable bit. With the enable at 0, events create no request. Clearing the enable leaves a pending request at 0.
- R4: Suppose an event line is first sampled high at clock edge k while the enable is 1 and no request is pending. Then `irq_n` falls at edge k+2.
- R5: Only a rising edge of an event line creates a request. A line that stays high creates no further request after a clear.
- R6: The counter increments by one on each 1-to-0 transition of `irq_n`, and at no other time. It wraps from all-ones to zero.
- R7: `cpu_rst_n` leaves the counter unchanged. Only `por_n` low clears it to zero.
- R8: If a new edge arrives while the enable is 1, in the same cycle as a clear write, `irq_n` is 0 after that edge. If a request was already pending, the counter does not change.
- R9: `rd_data` is combinational from `rd_addr`. Address 0 returns the enable in bit 0, with zeros above. Address 2 returns the counter, zero-extended. Addresses 1 and 3 return zero.
- R10: Rising edges on several event lines at the same edge create a single request and a single count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cpu_rst_n | input | 1 | Processor-path reset, asynchronous active low; clears enable, synchronizers and request |
| por_n | input | 1 | Power-on reset, asynchronous active low; clears the counter only |
| evt_async | input | N_SRC | Asynchronous event lines, one per source |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 service clear |
| wr_bit | input | 1 | Write data bit |
| rd_addr | input | 2 | Read address: 0 enable, 2 counter |
| rd_data | output | DATA_W | Read data |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bench builds the block with N_SRC=2 and CNT_W=4. Two lines make simultaneous edges on different sources possible. A 4-bit counter reaches its wrap point after sixteen requests, which is well within the run length. A behavioural model of the two-stage synchronizer delay and of the latch priority is compared with `irq_n` and `rd_data` on every clock. The scenarios include disabling while a request is pending, an event line held high across a clear, a clear that coincides with a set, and a processor reset that must not disturb the counter.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;
  localparam int ADDR_W = 2;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t ADDR_CTRL  = 2'd0;
  localparam reg_addr_t ADDR_CLEAR = 2'd1;
  localparam reg_addr_t ADDR_COUNT = 2'd2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/irq_evt_edge.sv
module irq_evt_edge #(
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_async,
  output logic             rise_o
);
  localparam int LAST = SYNC_STAGES - 1;
  logic [N_SRC-1:0] rise_vec;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [SYNC_STAGES-1:0] chain_q, chain_d;
    logic                   prev_q, prev_d;

    always_comb begin
      chain_d = {chain_q[SYNC_STAGES-2:0], evt_async[s]};
      prev_d  = chain_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
      end
    end

    assign rise_vec[s] = chain_q[LAST] & ~prev_q;
  end

  assign rise_o = |rise_vec;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o,
  output logic new_o
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (set_i)      req_d = 1'b1;
    else if (clr_i) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq_n_o = ~req_q;
  assign new_o   = set_i & ~req_q;
endmodule

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_hold_gen.sv
module irq_hold_gen
  import irq_hold_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                cpu_rst_n,
  input  logic                por_n,
  input  logic [N_SRC-1:0]    evt_async,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_bit,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq_n
);
  logic             rst_req_n;
  logic             rst_cnt_n;
  logic             rise_any;
  logic             en_q, en_d;
  logic             set_eff;
  logic             clr_hit;
  logic             new_req;
  logic [CNT_W-1:0] cnt_q;

  irq_rst_sync #(.STAGES(2)) u_rs_req (
    .clk(clk), .arst_n(cpu_rst_n), .rst_n_o(rst_req_n));
  irq_rst_sync #(.STAGES(2)) u_rs_cnt (
    .clk(clk), .arst_n(por_n), .rst_n_o(rst_cnt_n));

  irq_evt_edge #(.N_SRC(N_SRC), .SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_req_n), .evt_async(evt_async), .rise_o(rise_any));

  always_comb begin
    en_d = en_q;
    if (wr_stb && wr_addr == ADDR_CTRL) en_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_req_n) begin
    if (!rst_req_n) en_q <= 1'b0;
    else            en_q <= en_d;
  end

  assign set_eff = rise_any & en_q;
  assign clr_hit = wr_stb & (wr_addr == ADDR_CLEAR) & wr_bit;

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_req_n), .set_i(set_eff), .clr_i(clr_hit),
    .irq_n_o(irq_n), .new_o(new_req));

  irq_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_cnt_n), .inc_i(new_req), .cnt_o(cnt_q));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL:  rd_data[0] = en_q;
      ADDR_COUNT: rd_data[CNT_W-1:0] = cnt_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_hold_chk.sv
module irq_hold_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_req_n,
  input logic             rst_cnt_n,
  input logic             irq_n,
  input logic             wr_stb,
  input logic [1:0]       wr_addr,
  input logic             wr_bit,
  input logic             en_q,
  input logic             rise_any,
  input logic [CNT_W-1:0] cnt_q
);
  logic clr_w;
  assign clr_w = wr_stb && (wr_addr == 2'd1) && wr_bit;

  p_release_by_clear_r2: assert property (@(posedge clk) disable iff (!rst_req_n)
    $rose(irq_n) |-> $past(clr_w));

  p_pending_held_r2: assert property (@(posedge clk) disable iff (!rst_req_n)
    (!irq_n && !clr_w) |=> !irq_n);

  p_no_req_disabled_r3: assert property (@(posedge clk) disable iff (!rst_req_n)
    $fell(irq_n) |-> $past(en_q));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_req_n || !rst_cnt_n)
    $fell(irq_n) |-> (cnt_q == ($past(cnt_q) + 1'b1)));

  p_count_still_r6: assert property (@(posedge clk) disable iff (!rst_req_n || !rst_cnt_n)
    !$fell(irq_n) |-> $stable(cnt_q));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_req_n)
    (rise_any && en_q && clr_w) |=> !irq_n);
endmodule

bind irq_hold_gen irq_hold_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_req_n(rst_req_n), .rst_cnt_n(rst_cnt_n), .irq_n(irq_n),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_bit(wr_bit), .en_q(en_q),
  .rise_any(rise_any), .cnt_q(cnt_q));

// File: tb/sim_irq_hold_gen.sv
`timescale 1ns/100ps
module sim_irq_hold_gen;
  localparam int NS = 2;
  localparam int CW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          cpu_rst_n, por_n;
  logic [NS-1:0] evt;
  logic          wr_stb, wr_bit;
  logic [1:0]    wr_addr, rd_addr;
  logic [DW-1:0] rd_data;
  logic          irq_n;

  int total = 0, bad = 0;
  string cur_tag = "R1";

  // behavioural reference state
  int m_rq = 0, m_pc = 0, m_cnt = 0;
  bit m_req_n = 1, m_en = 0;
  bit [NS-1:0] h0 = 0, h1 = 0, h2 = 0;

  always #2 clk = ~clk;

  irq_hold_gen #(.N_SRC(NS), .CNT_W(CW), .DATA_W(DW)) u0 (
    .clk(clk), .cpu_rst_n(cpu_rst_n), .por_n(por_n), .evt_async(evt),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_rd(logic [1:0] a);
    if (a == 2'd0) return int'(m_en);
    if (a == 2'd2) return m_cnt;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit set, clr, nw;
    nw = 0;
    if (!cpu_rst_n) begin
      m_rq = 0; m_req_n = 1; m_en = 0; h0 = 0; h1 = 0; h2 = 0;
    end else if (m_rq < 2) begin
      m_rq++;
    end else begin
      set = (|(h1 & ~h2)) && m_en;
      clr = wr_stb && wr_addr == 2'd1 && wr_bit;
      nw  = set && m_req_n;
      if (set) m_req_n = 0;
      else if (clr) m_req_n = 1;
      if (wr_stb && wr_addr == 2'd0) m_en = wr_bit;
      h2 = h1; h1 = h0; h0 = evt;
    end
    if (!por_n) begin
      m_pc = 0; m_cnt = 0;
    end else if (m_pc < 2) begin
      m_pc++;
    end else if (nw) begin
      m_cnt = (m_cnt + 1) % (1 << CW);
    end
    #1;
    chk({cur_tag, " irq_n"}, int'(irq_n), int'(m_req_n));
    chk({cur_tag, " rd_data"}, int'(rd_data), m_rd(rd_addr));
  end

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic b);
    @(negedge clk); wr_stb = 1; wr_addr = a; wr_bit = b;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic fire(logic [NS-1:0] m);
    @(negedge clk); evt = m;
    nclk(2);
    evt = '0;
    nclk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    cpu_rst_n = 0; por_n = 0; evt = '0; wr_stb = 0; wr_bit = 0;
    wr_addr = 0; rd_addr = 2'd2;
    nclk(3);
    cpu_rst_n = 1; por_n = 1;
    nclk(4);
    // R1 reset state
    cur_tag = "R1";
    chk("R1 irq_n after reset", int'(irq_n), 1);
    rd_addr = 2'd0; #0.1;
    chk("R1 enable after reset", int'(rd_data), 0);
    rd_addr = 2'd2; #0.1;
    chk("R7 count after por", int'(rd_data), 0);

    // R9 unused read addresses
    cur_tag = "R9";
    rd_addr = 2'd3; nclk(1);
    chk("R9 addr3 reads zero", int'(rd_data), 0);
    rd_addr = 2'd1; nclk(1);
    chk("R9 addr1 reads zero", int'(rd_data), 0);
    rd_addr = 2'd2;

    // R3 disabled: no request
    cur_tag = "R3";
    fire(2'b01);
    chk("R3 no request while disabled", int'(irq_n), 1);

    // R4 latency and R2 hold
    cur_tag = "R4";
    wr(2'd0, 1'b1);
    fire(2'b01);
    chk("R4 request asserted", int'(irq_n), 0);
    cur_tag = "R2";
    wr(2'd0, 1'b1);
    wr(2'd1, 1'b0);
    nclk(3);
    chk("R2 still low after non-clear writes", int'(irq_n), 0);
    wr(2'd1, 1'b1);
    chk("R2 released by clear", int'(irq_n), 1);
    chk("R6 count one", int'(rd_data), 1);

    // R3 disable while pending
    cur_tag = "R3";
    fire(2'b10);
    wr(2'd0, 1'b0);
    nclk(4);
    chk("R3 pending kept after disable", int'(irq_n), 0);
    wr(2'd1, 1'b1);
    fire(2'b01);
    chk("R3 disabled after clear", int'(irq_n), 1);
    wr(2'd0, 1'b1);

    // R5 held-high event
    cur_tag = "R5";
    @(negedge clk); evt = 2'b01;
    nclk(5);
    chk("R5 request from held line", int'(irq_n), 0);
    wr(2'd1, 1'b1);
    nclk(6);
    chk("R5 no re-request while held", int'(irq_n), 1);
    evt = '0; nclk(4);

    // R10 simultaneous sources
    cur_tag = "R10";
    c0 = int'(rd_data);
    fire(2'b11);
    chk("R10 single count for two lines", int'(rd_data), (c0 + 1) % 16);
    wr(2'd1, 1'b1);

    // R8 set and clear in the same cycle, request pending
    cur_tag = "R8";
    fire(2'b01);
    c0 = int'(rd_data);
    @(negedge clk); evt = 2'b10;
    @(negedge clk);
    @(negedge clk); wr_stb = 1; wr_addr = 2'd1; wr_bit = 1;
    @(negedge clk); wr_stb = 0;
    chk("R8 set wins over clear", int'(irq_n), 0);
    chk("R8 no count for held request", int'(rd_data), c0);
    evt = '0;
    wr(2'd1, 1'b1);

    // R7 cpu reset leaves count
    cur_tag = "R7";
    fire(2'b01);
    c0 = int'(rd_data);
    @(negedge clk); cpu_rst_n = 0;
    nclk(2);
    chk("R1 irq_n released by cpu reset", int'(irq_n), 1);
    cpu_rst_n = 1; nclk(4);
    chk("R7 count survives cpu reset", int'(rd_data), c0);
    rd_addr = 2'd0; nclk(1);
    chk("R1 enable cleared by cpu reset", int'(rd_data), 0);
    rd_addr = 2'd2;

    // R6 wrap
    cur_tag = "R6";
    wr(2'd0, 1'b1);
    c0 = int'(rd_data);
    for (int i = 0; i < 17; i++) begin
      fire((i % 2 == 0) ? 2'b01 : 2'b10);
      wr(2'd1, 1'b1);
    end
    chk("R6 count after wrap", int'(rd_data), (c0 + 17) % 16);

    // R7 por clears count
    cur_tag = "R7";
    @(negedge clk); por_n = 0;
    nclk(2);
    por_n = 1; nclk(4);
    chk("R7 por clears count", int'(rd_data), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule